// File: doc/BRIEF.md
# External Interrupt Request Flag Bank

This block latches interrupt requests arriving on eight external request pins. Each pin passes through a two-stage synchronizer and then goes to a detector. A two-bit sense code per channel selects what counts as a request: a low level, a falling transition, a rising transition, or either transition. A detected request sets that channel's bit in an 8-bit flag register. Every flag drives a pending output toward the interrupt arbiter. Masking, prioritisation and vector generation live outside the block.

Three agents clear flags, and each has its own rule. Software clears a flag by writing 0 to its bit, and the write only takes effect if an earlier read returned that bit as 1. Exception processing acknowledges a channel with a strobe, and the effect of that strobe depends on the sense code. A transfer controller that starts on a channel's request clears that flag unless its clear-disable qualifier is set. A new request arriving in the same cycle as any clear keeps the flag set.

Top module: `irq_flag_bank`

## Requirements
- R1: After a synchronous reset, all flags, `pend_o` and `rd_data_o` are 0. The synchronizer and edge history reset to the high (idle) level, so a high pin sets nothing after reset.
- R2: Sense code 00 (low level) sets a channel's flag while its synchronized input is low. A pin driven low before clock edge k shows as a set flag after edge k+2, and not before.
- R3: Sense code 01 (falling) sets the flag on a high-to-low transition of the synchronized input, with the same latency as R2. A steady low or a rising transition sets nothing.
- R4: Sense code 10 (rising) sets the flag on a low-to-high transition only. A falling transition or a steady level sets nothing.
- R5: Sense code 11 (both) sets the flag on either transition.
- R6: In a register write, a data bit of 1 leaves the corresponding flag unchanged.
- R7: In a register write, a data bit of 0 clears the flag only if a read since that flag last cleared returned the bit as 1. A write with no such read leaves the flag set.
- R8: In low-level mode, an acknowledge strobe clears the flag only when the synchronized input is high.
- R9: In any edge mode (codes 01, 10, 11), an acknowledge strobe clears the flag regardless of the input level.
- R10: A transfer-start strobe clears the channel's flag when its keep qualifier is 0. With the qualifier at 1, the strobe has no effect.
- R11: A set event in the same cycle as any clear leaves the flag at 1. Any clear condition on a bit cancels that bit's read qualification, so another read is needed before a write-0 can clear it.
- R12: `pend_o` and `rd_data_o` both equal the flag register at all times. The read data is valid in the same cycle as `rd_en_i`.

Sense code of channel n is `sense_i[2n+1:2n]`, with bit 2n+1 as the high bit. Flag of channel n is bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin_i | input | 8 | External request pins, bit n = channel n |
| sense_i | input | 16 | Sense codes, channel n at [2n+1:2n] |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data (0 requests a clear) |
| rd_data_o | output | 8 | Flag register read data |
| ack_i | input | 8 | Per-channel exception acknowledge strobes |
| xfer_start_i | input | 8 | Per-channel transfer-controller start strobes |
| xfer_keep_i | input | 8 | Per-channel clear-disable qualifiers (1 keeps the flag) |
| pend_o | output | 8 | Per-channel pending outputs |

## Verification
A wrong synchronizer depth or a bad edge-history register moves the first visible flag off its two-edge latency, or makes a flag appear on the wrong transition. Either error shows on `pend_o` within three cycles of the pin change. A bad read-qualification bit shows as a write-0 that clears too early or not at all, in the cycle after the write. A wrong mode-dependent clear shows in the cycle after an acknowledge or transfer strobe. A cycle-accurate model in the bench compares every output every cycle, so any such divergence is reported in the cycle where it first appears.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_BOTH = 2'b11
  } sense_e;

  function automatic sense_e sense_of(input logic [1:0] code);
    return sense_e'(code);
  endfunction
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int   W       = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= {W{RST_VAL}};
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= {W{RST_VAL}};
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqf_detect.sv
module irqf_detect
  import irqf_pkg::*;
#(
  parameter int NCH = 8,
  localparam int SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lvl_i,
  input  logic [SW-1:0]  sense_i,
  output logic [NCH-1:0] set_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl_i;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic fall, rise;
    assign fall = prev_q[n] & ~lvl_i[n];
    assign rise = ~prev_q[n] & lvl_i[n];
    always_comb begin
      unique case (sense_of(sense_i[2*n+1 -: 2]))
        SNS_LOW:  set_o[n] = ~lvl_i[n];
        SNS_FALL: set_o[n] = fall;
        SNS_RISE: set_o[n] = rise;
        SNS_BOTH: set_o[n] = fall | rise;
        default:  set_o[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags
  import irqf_pkg::*;
#(
  parameter int NCH = 8,
  localparam int SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] lvl_i,
  input  logic [SW-1:0]  sense_i,
  input  logic           rd_en_i,
  input  logic           wr_en_i,
  input  logic [NCH-1:0] wr_data_i,
  input  logic [NCH-1:0] ack_i,
  input  logic [NCH-1:0] xfer_start_i,
  input  logic [NCH-1:0] xfer_keep_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] qual_o
);
  logic [NCH-1:0] flag_q, qual_q;
  logic [NCH-1:0] clr, flag_d, qual_d;

  for (genvar n = 0; n < NCH; n++) begin : g_clr
    logic sw_clr, ack_clr, xfer_clr;
    assign sw_clr   = wr_en_i & ~wr_data_i[n] & qual_q[n];
    assign xfer_clr = xfer_start_i[n] & ~xfer_keep_i[n];
    always_comb begin
      if (sense_of(sense_i[2*n+1 -: 2]) == SNS_LOW) ack_clr = ack_i[n] & lvl_i[n];
      else                                          ack_clr = ack_i[n];
    end
    assign clr[n] = sw_clr | ack_clr | xfer_clr;
  end

  always_comb begin
    flag_d = (flag_q & ~clr) | set_i;
    qual_d = rd_en_i ? flag_q : qual_q;
    qual_d = qual_d & ~clr & flag_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      qual_q <= '0;
    end else begin
      flag_q <= flag_d;
      qual_q <= qual_d;
    end
  end

  assign flag_o = flag_q;
  assign qual_o = qual_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_pin_i,
  input  logic [SW-1:0]  sense_i,
  input  logic           rd_en_i,
  input  logic           wr_en_i,
  input  logic [NCH-1:0] wr_data_i,
  output logic [NCH-1:0] rd_data_o,
  input  logic [NCH-1:0] ack_i,
  input  logic [NCH-1:0] xfer_start_i,
  input  logic [NCH-1:0] xfer_keep_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] lvl, set_evt, flag, qual;

  irqf_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(req_pin_i), .q_o(lvl)
  );

  irqf_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst(rst), .lvl_i(lvl), .sense_i(sense_i), .set_o(set_evt)
  );

  irqf_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_evt), .lvl_i(lvl), .sense_i(sense_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .xfer_start_i(xfer_start_i), .xfer_keep_i(xfer_keep_i),
    .flag_o(flag), .qual_o(qual)
  );

  assign pend_o    = flag;
  assign rd_data_o = flag;
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int NCH = 8,
  localparam int SW = 2 * NCH
) (
  input logic           clk,
  input logic           rst,
  input logic [SW-1:0]  sense_i,
  input logic           wr_en_i,
  input logic [NCH-1:0] wr_data_i,
  input logic [NCH-1:0] ack_i,
  input logic [NCH-1:0] xfer_start_i,
  input logic [NCH-1:0] xfer_keep_i,
  input logic [NCH-1:0] pend_o,
  input logic [NCH-1:0] set_evt,
  input logic [NCH-1:0] qual
);
  logic [NCH-1:0] edge_mode;
  for (genvar n = 0; n < NCH; n++) begin : g_mode
    assign edge_mode[n] = |sense_i[2*n+1 -: 2];
  end

  // R2: a flag only rises after a detected request
  assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_evt)) == '0));

  // R6: write data 1 never clears a flag
  assert_wr_one_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (($past(pend_o) & $past(wr_data_i) & ~$past(ack_i)
                  & ~$past(xfer_start_i) & ~pend_o) == '0));

  // R7: write 0 without read qualification does not clear
  assert_write_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (($past(pend_o) & ~$past(qual) & ~$past(ack_i)
                  & ~$past(xfer_start_i) & ~pend_o) == '0));

  // R9: acknowledge in edge mode clears
  assert_edge_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(ack_i) & $past(edge_mode) & ~$past(set_evt)) == '0));

  // R10: transfer start with keep 0 clears
  assert_xfer_clears_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(xfer_start_i) & ~$past(xfer_keep_i)
               & ~$past(set_evt)) == '0));

  // R11: set wins over any clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & $past(set_evt)) == $past(set_evt)));
endmodule

bind irq_flag_bank irqf_checker #(.NCH(NCH)) i_irqf_checker (
  .clk(clk), .rst(rst), .sense_i(sense_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .ack_i(ack_i), .xfer_start_i(xfer_start_i),
  .xfer_keep_i(xfer_keep_i), .pend_o(pend_o), .set_evt(set_evt), .qual(qual)
);

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int SW  = 2 * NCH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] pins = '1;
  logic [SW-1:0]  sense = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [NCH-1:0] wr_data = '0, ack = '0, xs = '0, keep = '0;
  logic [NCH-1:0] rd_data, pend;

  int errors = 0, checks = 0;

  // reference model state
  logic [NCH-1:0] m_s1, m_s2, m_prev, m_flag, m_qual;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_bank #(.NCH(NCH)) i_irq_flag_bank (
    .clk(clk), .rst(rst), .req_pin_i(pins), .sense_i(sense),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .ack_i(ack), .xfer_start_i(xs), .xfer_keep_i(keep), .pend_o(pend)
  );

  task automatic model_update();
    logic [NCH-1:0] setv, clrv, fn, qn;
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_prev = '1; m_flag = '0; m_qual = '0;
      return;
    end
    for (int n = 0; n < NCH; n++) begin
      logic [1:0] c;
      logic fall, rise;
      c    = sense[2*n+1 -: 2];
      fall = m_prev[n] & ~m_s2[n];
      rise = ~m_prev[n] & m_s2[n];
      case (c)
        2'b00:   setv[n] = ~m_s2[n];
        2'b01:   setv[n] = fall;
        2'b10:   setv[n] = rise;
        default: setv[n] = fall | rise;
      endcase
      clrv[n] = (wr_en & ~wr_data[n] & m_qual[n])
              | (xs[n] & ~keep[n])
              | (ack[n] & ((c != 2'b00) | m_s2[n]));
    end
    fn = (m_flag & ~clrv) | setv;
    qn = (rd_en ? m_flag : m_qual) & ~clrv & fn;
    m_flag = fn; m_qual = qn;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
  endtask

  task automatic tick(int k = 1);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  task automatic do_write(logic [NCH-1:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(3); rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // ch7..ch0 sense: both, rise, low, fall, both, low, rise, fall
    sense = 16'hE1C9;
    @(negedge clk);
    do_reset();
    check("R1 reset pend", pend, 8'h00);
    check("R1 reset rd_data", rd_data, 8'h00);
    tick(4);
    check("R1 idle high pins set nothing", pend, 8'h00);

    // R3 falling on ch0, latency
    pins[0] = 1'b0; tick(2);
    check("R3 not yet after two edges", pend, 8'h00);
    tick();
    check("R3 falling sets ch0", pend, 8'h01);
    // R7 write without read
    do_write(8'h00);
    check("R7 unread write keeps", pend, 8'h01);
    rd_en = 1'b1;
    check("R12 read data same cycle", rd_data, 8'h01);
    tick(); rd_en = 1'b0;
    do_write(8'h00);
    check("R7 read-then-write clears", pend, 8'h00);
    tick(3);
    check("R3 steady low sets nothing", pend, 8'h00);

    // R4 rising on ch1
    pins[1] = 1'b0; tick(3);
    check("R4 falling ignored", pend, 8'h00);
    pins[1] = 1'b1; tick(3);
    check("R4 rising sets ch1", pend, 8'h02);
    do_read();
    do_write(8'hFF);
    check("R6 write one keeps", pend, 8'h02);
    do_write(8'h00);
    check("R7 clear ch1", pend, 8'h00);

    // R2 / R8 low level on ch2
    pins[2] = 1'b0; tick(3);
    check("R2 low level sets ch2", pend, 8'h04);
    ack[2] = 1'b1; tick(); ack[2] = 1'b0;
    check("R8 ack while low keeps", pend, 8'h04);
    pins[2] = 1'b1; tick(3);
    check("R2 flag held after pin high", pend, 8'h04);
    ack[2] = 1'b1; tick(); ack[2] = 1'b0;
    check("R8 ack while high clears", pend, 8'h00);

    // R5 / R9 both edges on ch3
    pins[3] = 1'b0; tick(3);
    check("R5 falling sets ch3", pend, 8'h08);
    ack[3] = 1'b1; tick(); ack[3] = 1'b0;
    check("R9 edge ack clears with pin low", pend, 8'h00);
    pins[3] = 1'b1; tick(3);
    check("R5 rising sets ch3", pend, 8'h08);
    ack[3] = 1'b1; tick(); ack[3] = 1'b0;
    check("R9 edge ack clears", pend, 8'h00);

    // R10 transfer start on ch4
    pins[4] = 1'b0; tick(3);
    check("R10 ch4 set", pend, 8'h10);
    xs[4] = 1'b1; keep[4] = 1'b1; tick();
    check("R10 keep qualifier holds", pend, 8'h10);
    keep[4] = 1'b0; tick(); xs[4] = 1'b0;
    check("R10 start clears", pend, 8'h00);

    // R11 set wins, qualification discarded, ch5 low level
    pins[5] = 1'b0; tick(3);
    check("R11 ch5 set", pend, 8'h20);
    do_read();
    do_write(8'h00);
    check("R11 set wins over write clear", pend, 8'h20);
    pins[5] = 1'b1; tick(3);
    do_write(8'h00);
    check("R11 qualification discarded", pend, 8'h20);
    do_read();
    do_write(8'h00);
    check("R11 fresh read then clear", pend, 8'h00);

    // constrained random against model
    do_reset();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      pins  = pins ^ (NCH'($urandom) & NCH'($urandom) & NCH'($urandom));
      if (($urandom % 64) == 0) sense = SW'($urandom);
      rd_en   = (($urandom % 3) == 0);
      wr_en   = (($urandom % 4) == 0);
      wr_data = NCH'($urandom);
      ack     = NCH'($urandom) & NCH'($urandom);
      xs      = NCH'($urandom) & NCH'($urandom);
      keep    = NCH'($urandom);
      tick();
      check("R12 pend vs model", pend, m_flag);
      check("R12 rd_data vs pend", rd_data, pend);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule